// File: doc/BRIEF.md
# Cascadable Serial-Loaded Three-Channel PWM Controller

This block takes a 31-bit word over a three-wire serial link (serial clock, serial data, latch strobe) and drives three PWM outputs from it. Words go into a shift register. A rising latch edge copies the word into one of two banks. A word with its top bit clear carries three 10-bit duty values. A word with its top bit set carries three 7-bit current-scale codes and a 2-bit PWM prescale code. A shared 10-bit counter, clocked through the prescaler, compares against each duty value to form the channel outputs. An active-low output enable blanks all three outputs.

The block is meant for long chains of identical devices. The serial output presents the bit leaving the shift register, and it changes only on the falling serial-clock edge, so the next stage, which shifts on rising edges, always sees settled data. The serial clock, latch and enable inputs are forwarded one system clock later to feed the next stage. All serial inputs are sampled by the system clock, so each level of each serial input must be held for at least one system clock period.

Top module: `rgb_chain_pwm`

## Requirements
- R1: A rising serial-clock edge shifts the register left by one place and takes `ser_din` into bit 0, so the first bit sent ends up in bit 30.
- R2: `ser_dout` takes the value of shift-register bit 30 only on a falling serial-clock edge and holds it at all other times.
- R3: A rising latch edge with bit 30 clear loads the duty bank: channel 0 from bits 0–9, channel 1 from bits 10–19, channel 2 from bits 20–29.
- R4: A rising latch edge with bit 30 set loads the control bank: scale codes from bits 0–6, 10–16 and 20–26 (shown on `scale_o` as channel 0 in its low 7 bits, channel 1 next, channel 2 on top) and the prescale code from bits 7–8. The duty bank is left unchanged. Bits 9, 17–19 and 27–29 are ignored.
- R5: Prescale codes 0, 1, 2 and 3 advance the PWM counter once every 1, 2, 4 or 8 system clocks. A channel is high while the counter is below its duty value, so over one full period of 1024·2^code clocks it is high for duty·2^code clocks.
- R6: While `oe_n` is high, all PWM outputs are low. Both banks keep their contents, and the outputs return to their previous duty once `oe_n` goes low again.
- R7: `clk_fwd`, `lat_fwd` and `oe_n_fwd` repeat `ser_clk`, `ser_lat` and `oe_n` one system clock later.
- R8: After reset, both banks, the shift register, `ser_dout`, the forwarded outputs and the PWM outputs are all zero.
- R9: When a rising latch edge and a rising serial-clock edge are seen in the same system clock, the bank receives the shift-register contents from before that shift.
- R10: Neither bank changes except on a rising latch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial inputs and drives the PWM counter |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock from the previous stage |
| ser_din | input | 1 | Serial data from the previous stage |
| ser_lat | input | 1 | Latch strobe; acts on its rising edge |
| oe_n | input | 1 | Active-low output enable |
| ser_dout | output | 1 | Serial data to the next stage, changes on falling serial-clock edges |
| clk_fwd | output | 1 | Serial clock forwarded to the next stage |
| lat_fwd | output | 1 | Latch strobe forwarded to the next stage |
| oe_n_fwd | output | 1 | Output enable forwarded to the next stage |
| pwm_out | output | 3 | PWM outputs, bit n is channel n |
| scale_o | output | 21 | Latched 7-bit current-scale codes, channel 0 in the low bits |

## Verification
A latch edge and a shift edge can be detected in the same system clock. The bench provokes this by raising `ser_clk` and `ser_lat` at the same instant, just after a full control word has been shifted in. It then requires `scale_o` to show that word's scale codes, not the codes of the word moved one place further. A second overlap is the falling serial-clock edge meeting the next bit's data change. The bench shifts one word behind another and checks that `ser_dout` presents the earlier word, bit 30 first, one bit per falling edge. Duty decoding is checked by counting high cycles over a full PWM period for each prescale code.

// File: rtl/rgb_chain_pwm.sv
module rgb_chain_pwm #(
  parameter int NCH = 3,
  parameter int DW  = 10,
  parameter int SW  = 7,
  parameter int PSW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_lat,
  input  logic              oe_n,
  output logic              ser_dout,
  output logic              clk_fwd,
  output logic              lat_fwd,
  output logic              oe_n_fwd,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH*SW-1:0] scale_o
);
  localparam int SRW = NCH * DW + 1;
  localparam int PCW = (1 << PSW) - 1;

  logic [SRW-1:0]    sr;
  logic [NCH*DW-1:0] duty;
  logic [PSW-1:0]    div;
  logic [DW-1:0]     cnt;
  logic [PCW-1:0]    pre;
  logic [PCW-1:0]    lim;
  logic [NCH-1:0]    pwm_nxt;

  wire sck_rise = ser_clk & ~clk_fwd;
  wire sck_fall = ~ser_clk & clk_fwd;
  wire lat_rise = ser_lat & ~lat_fwd;
  wire bank_sel = sr[SRW-1];

  assign lim = PCW'((1 << div) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_fwd  <= 1'b0;
      lat_fwd  <= 1'b0;
      oe_n_fwd <= 1'b0;
      sr       <= '0;
      ser_dout <= 1'b0;
      duty     <= '0;
      scale_o  <= '0;
      div      <= '0;
    end else begin
      clk_fwd  <= ser_clk;
      lat_fwd  <= ser_lat;
      oe_n_fwd <= oe_n;
      if (sck_rise) sr <= {sr[SRW-2:0], ser_din};
      if (sck_fall) ser_dout <= sr[SRW-1];
      if (lat_rise) begin
        if (bank_sel) begin
          for (int i = 0; i < NCH; i++) scale_o[i*SW +: SW] <= sr[i*DW +: SW];
          div <= sr[SW +: PSW];
        end else begin
          duty <= sr[NCH*DW-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (pre >= lim) begin
      pre <= '0;
      cnt <= cnt + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_comb
    for (int i = 0; i < NCH; i++) pwm_nxt[i] = ~oe_n & (cnt < duty[i*DW +: DW]);

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_out <= '0;
    else        pwm_out <= pwm_nxt;
  end

  p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(ser_dout));

  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> pwm_out == '0);

  p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (clk_fwd == $past(ser_clk)) && (lat_fwd == $past(ser_lat)) && (oe_n_fwd == $past(oe_n)));

  p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> $stable(duty) && $stable(scale_o) && $stable(div));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> cnt == DW'($past(cnt) + 1'b1));

  p_ctrl_keeps_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && bank_sel) |=> $stable(duty));
endmodule

// File: tb/rgb_chain_pwm_tb.sv
module rgb_chain_pwm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_lat = 1'b0, oe_n = 1'b0;
  logic ser_dout, clk_fwd, lat_fwd, oe_n_fwd;
  logic [2:0]  pwm_out;
  logic [20:0] scale_o;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  rgb_chain_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_lat(ser_lat), .oe_n(oe_n), .ser_dout(ser_dout), .clk_fwd(clk_fwd),
    .lat_fwd(lat_fwd), .oe_n_fwd(oe_n_fwd), .pwm_out(pwm_out), .scale_o(scale_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [30:0] duty_word(input int a, input int b, input int c);
    return {1'b0, c[9:0], b[9:0], a[9:0]};
  endfunction

  function automatic logic [30:0] ctrl_word(input int s0, input int s1, input int s2, input int d);
    return {1'b1, 2'b11, 1'b1, s2[6:0], 3'b101, s1[6:0], 1'b1, d[1:0], s0[6:0]};
  endfunction

  task automatic shift_word(input logic [30:0] w, input bit do_chk, input logic [30:0] prev);
    for (int i = 30; i >= 0; i--) begin
      ser_din = w[i];
      ser_clk = 1'b0;
      tick(2);
      if (do_chk) chk(ser_dout == prev[i], "R2 R1 chained serial out", int'(ser_dout), int'(prev[i]));
      ser_clk = 1'b1;
      tick(2);
    end
    ser_clk = 1'b0;
    tick(2);
  endtask

  task automatic latch();
    ser_lat = 1'b1;
    tick(2);
    ser_lat = 1'b0;
    tick(2);
  endtask

  task automatic measure(input int d, input int e0, input int e1, input int e2, input string req);
    int h0 = 0, h1 = 0, h2 = 0;
    tick(20);
    for (int k = 0; k < (1024 << d); k++) begin
      h0 += int'(pwm_out[0]);
      h1 += int'(pwm_out[1]);
      h2 += int'(pwm_out[2]);
      tick(1);
    end
    chk(h0 == (e0 << d), {req, " ch0"}, h0, e0 << d);
    chk(h1 == (e1 << d), {req, " ch1"}, h1, e1 << d);
    chk(h2 == (e2 << d), {req, " ch2"}, h2, e2 << d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [30:0] prev;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R8 reset state
    chk(pwm_out == 3'b0, "R8 pwm reset", int'(pwm_out), 0);
    chk(scale_o == 21'b0, "R8 scale reset", int'(scale_o), 0);
    chk(ser_dout == 1'b0, "R8 dout reset", int'(ser_dout), 0);
    chk({clk_fwd, lat_fwd, oe_n_fwd} == 3'b0, "R8 fwd reset", int'({clk_fwd, lat_fwd, oe_n_fwd}), 0);
    measure(0, 0, 0, 0, "R8 idle pwm");

    // R7 forwarding
    ser_clk = 1'b1; ser_lat = 1'b1; oe_n = 1'b1;
    tick(1);
    chk({clk_fwd, lat_fwd, oe_n_fwd} == 3'b111, "R7 fwd high", int'({clk_fwd, lat_fwd, oe_n_fwd}), 7);
    ser_clk = 1'b0; ser_lat = 1'b0; oe_n = 1'b0;
    tick(1);
    chk({clk_fwd, lat_fwd, oe_n_fwd} == 3'b000, "R7 fwd low", int'({clk_fwd, lat_fwd, oe_n_fwd}), 0);
    tick(2);

    // R3 duty decode, R5 base prescale
    prev = duty_word(100, 513, 1023);
    shift_word(prev, 1'b0, '0);
    latch();
    measure(0, 100, 513, 1023, "R3 R5 duty d0");

    // R4 control bank, R5 prescale codes, R2 chained output
    for (int d = 1; d <= 3; d++) begin
      logic [30:0] w;
      w = ctrl_word(d * 11, 64 + d, 127 - d, d);
      shift_word(w, 1'b1, prev);
      prev = w;
      latch();
      chk(scale_o == {7'(127 - d), 7'(64 + d), 7'(d * 11)}, "R4 scale decode",
          int'(scale_o), int'({7'(127 - d), 7'(64 + d), 7'(d * 11)}));
      measure(d, 100, 513, 1023, "R4 R5 duty kept prescaled");
    end

    // R3 duty boundaries at largest prescale
    begin
      logic [30:0] w;
      w = duty_word(0, 1, 1022);
      shift_word(w, 1'b1, prev);
      prev = w;
      latch();
      chk(scale_o == {7'd124, 7'd67, 7'd33}, "R3 duty word leaves scale", int'(scale_o),
          int'({7'd124, 7'd67, 7'd33}));
      measure(3, 0, 1, 1022, "R3 R5 duty edges d3");
    end

    // R6 blanking keeps state
    oe_n = 1'b1;
    measure(3, 0, 0, 0, "R6 blanked");
    oe_n = 1'b0;
    measure(3, 0, 1, 1022, "R6 restored");

    // R9 latch and shift edges in one clock
    begin
      logic [30:0] w;
      w = ctrl_word(7, 55, 120, 0);
      shift_word(w, 1'b1, prev);
      ser_din = 1'b1;
      ser_clk = 1'b1;
      ser_lat = 1'b1;
      tick(2);
      ser_lat = 1'b0;
      ser_clk = 1'b0;
      tick(2);
      chk(scale_o == {7'd120, 7'd55, 7'd7}, "R9 pre-shift capture", int'(scale_o),
          int'({7'd120, 7'd55, 7'd7}));
      measure(0, 0, 1, 1022, "R9 R10 duty kept");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule